// File: doc/BRIEF.md
# ADC Conversion and Power-Mode Sequencer

This block is the digital control core of a serial-output successive-approximation converter. An active-low convert-start strobe starts a conversion timer. When the timer runs out, the block captures the finished result word from an input bus. It then looks at the level of the strobe to choose its next state. If the strobe is high, the block stays powered and ready for the next conversion. If the strobe is low, the block enters power-down. Waking from power-down takes a fixed power-up interval, and a start request that arrives during that interval is carried out as soon as the interval ends.

The block also holds the latest result for a host that reads it over a frame-sync plus serial-clock port. A read that starts before a conversion completes returns the older word. If a conversion completes while a read is in flight, its word waits in a side register and takes effect once that read is over. All timing is counted in system-clock cycles, and those counts are derived from parameters that give the clock frequency and the analog intervals in nanoseconds.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `busy`, `pwr_down` and `dout` are all low, and the held result is zero.
- R2: A high-to-low transition on `convst_n` while powered and idle starts a conversion. `busy` rises on the next clock and stays high for exactly CONV_CYC = ceil(CLK_MHZ*CONV_NS/1000) cycles, which is 575 at the defaults. Further transitions of `convst_n` during a conversion are ignored.
- R3: When a conversion completes, the block samples `convst_n` on that same clock. High keeps the block powered, so `pwr_down` stays low. Low sets `pwr_down` high.
- R4: While powered down, a low-to-high transition on `convst_n` clears `pwr_down` and begins a power-up interval of PWRUP_CYC cycles (375 at the defaults). No conversion starts before that interval has elapsed.
- R5: A high-to-low transition on `convst_n` during power-up is remembered. The conversion starts on the clock that ends the power-up interval.
- R6: On the clock that completes a conversion, `result_in` is captured as that conversion's result. The capture happens in both the powered and the power-down outcomes.
- R7: A rising edge on `rfs` arms the port, but `dout` stays low until the first rising edge of `sclk` after the arming edge. That `sclk` edge presents the MSB of the held result. Each later `sclk` rising edge presents the next lower bit, and the `sclk` rising edge after the LSB ends the read. Driving `rfs` low ends a read at once.
- R8: `dout` is low whenever no read is shifting.
- R9: A read that starts before a conversion completes returns the previous result. A read that starts after the completion returns the new one.
- R10: If a conversion completes during a read, the read in flight keeps returning the older word. The new word is loaded once that read ends, and the next read returns it.
- R11: Reading again without a new conversion returns the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| convst_n | input | 1 | Active-low convert-start and power-mode strobe |
| result_in | input | DATA_W | Conversion result word, captured when a conversion completes |
| rfs | input | 1 | Read frame sync, active high |
| sclk | input | 1 | Serial read clock, sampled by `clk` |
| dout | output | 1 | Serial data out, MSB first |
| busy | output | 1 | High while a conversion is running |
| pwr_down | output | 1 | High while the block is powered down |

## Verification
Reads are placed at several offsets from the convert-start strobe: well before completion, across the completion clock, just after it, and long after it. This tells apart an older word, a word held pending, and a freshly captured word. Back-to-back reads of one result separate a shifter that is reloaded on each read from one that is consumed. The strobe is left high or left low through the completion clock, which distinguishes the two power outcomes. A wake-up with a strobe pulse inside the power-up window pins down the exact cycle on which the deferred conversion begins.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CONV  = 2'd1,
      ST_PWRDN = 2'd2,
      ST_PWRUP = 2'd3
   } pwr_state_t;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_kind_t;

   // Round a duration in ns up to whole clock cycles.
   function automatic int unsigned ns_to_cycles(input int unsigned mhz, input int unsigned ns);
      return (mhz * ns + 999) / 1000;
   endfunction

endpackage

// File: rtl/adc_edge_det.sv
module adc_edge_det
   import adc_seq_pkg::*;
#(
   parameter edge_kind_t KIND    = EDGE_RISE,
   parameter logic       RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig,
   output logic edge_o
);

   logic sig_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sig_q <= RST_VAL;
      else        sig_q <= sig;
   end

   generate
      if (KIND == EDGE_RISE) begin : g_rise
         assign edge_o = sig & ~sig_q;
      end else begin : g_fall
         assign edge_o = ~sig & sig_q;
      end
   endgenerate

endmodule

// File: rtl/adc_pwr_fsm.sv
module adc_pwr_fsm
   import adc_seq_pkg::*;
#(
   parameter int unsigned CONV_CYC  = 575,
   parameter int unsigned PWRUP_CYC = 375
) (
   input  logic clk,
   input  logic rst_n,
   input  logic convst_n,
   input  logic cs_rise,
   input  logic cs_fall,
   output logic conv_done,
   output logic busy,
   output logic pwr_down
);

   localparam int unsigned MAXC = (CONV_CYC > PWRUP_CYC) ? CONV_CYC : PWRUP_CYC;
   localparam int unsigned CW   = (MAXC < 2) ? 1 : $clog2(MAXC);
   localparam logic [CW-1:0] CONV_LAST  = CW'(CONV_CYC - 1);
   localparam logic [CW-1:0] PWRUP_LAST = CW'(PWRUP_CYC - 1);

   pwr_state_t      st;
   logic [CW-1:0]   cnt;
   logic            start_pend;
   logic            cnt_zero;

   assign cnt_zero  = (cnt == '0);
   assign conv_done = (st == ST_CONV) && cnt_zero;
   assign busy      = (st == ST_CONV);
   assign pwr_down  = (st == ST_PWRDN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         cnt        <= '0;
         start_pend <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (cs_fall) begin
                  st  <= ST_CONV;
                  cnt <= CONV_LAST;
               end
            end
            ST_CONV: begin
               if (cnt_zero) begin
                  st <= convst_n ? ST_IDLE : ST_PWRDN;
               end else begin
                  cnt <= cnt - CW'(1);
               end
            end
            ST_PWRDN: begin
               if (cs_rise) begin
                  st         <= ST_PWRUP;
                  cnt        <= PWRUP_LAST;
                  start_pend <= 1'b0;
               end
            end
            ST_PWRUP: begin
               if (cnt_zero) begin
                  start_pend <= 1'b0;
                  if (start_pend || cs_fall) begin
                     st  <= ST_CONV;
                     cnt <= CONV_LAST;
                  end else begin
                     st <= ST_IDLE;
                  end
               end else begin
                  cnt <= cnt - CW'(1);
                  if (cs_fall) start_pend <= 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/adc_serial_out.sv
module adc_serial_out #(
   parameter int unsigned DATA_W    = 10,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] result_in,
   input  logic              rfs,
   input  logic              rfs_rise,
   input  logic              sclk_rise,
   output logic              dout
);

   localparam int unsigned BW = $clog2(DATA_W);
   localparam logic [BW-1:0] LAST_IDX = BW'(DATA_W - 1);

   logic              armed;
   logic              active;
   logic [BW-1:0]     bit_idx;
   logic [DATA_W-1:0] held;
   logic [DATA_W-1:0] pend;
   logic              pend_v;
   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] shreg_nxt;
   logic              out_bit;
   logic              in_read;

   assign in_read = armed | active;

   generate
      if (MSB_FIRST) begin : g_msb
         assign out_bit   = shreg[DATA_W-1];
         assign shreg_nxt = {shreg[DATA_W-2:0], 1'b0};
      end else begin : g_lsb
         assign out_bit   = shreg[0];
         assign shreg_nxt = {1'b0, shreg[DATA_W-1:1]};
      end
   endgenerate

   assign dout = active & out_bit;

   // Frame control and shifter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         active  <= 1'b0;
         bit_idx <= '0;
         shreg   <= '0;
      end else if (!rfs) begin
         armed  <= 1'b0;
         active <= 1'b0;
      end else begin
         if (rfs_rise) armed <= 1'b1;
         if (sclk_rise) begin
            if (armed && !active) begin
               active  <= 1'b1;
               bit_idx <= '0;
               shreg   <= held;
            end else if (active) begin
               if (bit_idx == LAST_IDX) begin
                  active <= 1'b0;
                  armed  <= 1'b0;
               end else begin
                  shreg   <= shreg_nxt;
                  bit_idx <= bit_idx + BW'(1);
               end
            end
         end
      end
   end

   // Result holding with deferral across a read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held   <= '0;
         pend   <= '0;
         pend_v <= 1'b0;
      end else if (conv_done) begin
         if (in_read) begin
            pend   <= result_in;
            pend_v <= 1'b1;
         end else begin
            held   <= result_in;
            pend_v <= 1'b0;
         end
      end else if (pend_v && !in_read) begin
         held   <= pend;
         pend_v <= 1'b0;
      end
   end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int unsigned CLK_MHZ   = 250,
   parameter int unsigned CONV_NS   = 2300,
   parameter int unsigned PWRUP_NS  = 1500,
   parameter int unsigned DATA_W    = 10,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              convst_n,
   input  logic [DATA_W-1:0] result_in,
   input  logic              rfs,
   input  logic              sclk,
   output logic              dout,
   output logic              busy,
   output logic              pwr_down
);

   localparam int unsigned CONV_CYC  = ns_to_cycles(CLK_MHZ, CONV_NS);
   localparam int unsigned PWRUP_CYC = ns_to_cycles(CLK_MHZ, PWRUP_NS);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (CONV_CYC < 2) begin : g_bad_conv
         $error("conversion interval must span at least 2 cycles");
      end
      if (PWRUP_CYC < 1) begin : g_bad_pwrup
         $error("power-up interval must span at least 1 cycle");
      end
   endgenerate

   logic cs_fall, cs_rise, rfs_rise, sclk_rise, conv_done;

   adc_edge_det #(.KIND(EDGE_FALL), .RST_VAL(1'b1)) u_cs_fall (
      .clk(clk), .rst_n(rst_n), .sig(convst_n), .edge_o(cs_fall));
   adc_edge_det #(.KIND(EDGE_RISE), .RST_VAL(1'b1)) u_cs_rise (
      .clk(clk), .rst_n(rst_n), .sig(convst_n), .edge_o(cs_rise));
   adc_edge_det #(.KIND(EDGE_RISE), .RST_VAL(1'b0)) u_rfs_rise (
      .clk(clk), .rst_n(rst_n), .sig(rfs), .edge_o(rfs_rise));
   adc_edge_det #(.KIND(EDGE_RISE), .RST_VAL(1'b0)) u_sclk_rise (
      .clk(clk), .rst_n(rst_n), .sig(sclk), .edge_o(sclk_rise));

   adc_pwr_fsm #(.CONV_CYC(CONV_CYC), .PWRUP_CYC(PWRUP_CYC)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .convst_n  (convst_n),
      .cs_rise   (cs_rise),
      .cs_fall   (cs_fall),
      .conv_done (conv_done),
      .busy      (busy),
      .pwr_down  (pwr_down)
   );

   adc_serial_out #(.DATA_W(DATA_W), .MSB_FIRST(MSB_FIRST)) u_ser (
      .clk       (clk),
      .rst_n     (rst_n),
      .conv_done (conv_done),
      .result_in (result_in),
      .rfs       (rfs),
      .rfs_rise  (rfs_rise),
      .sclk_rise (sclk_rise),
      .dout      (dout)
   );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
   parameter int unsigned CONV_CYC  = 575,
   parameter int unsigned PWRUP_CYC = 375
) (
   input logic clk,
   input logic rst_n,
   input logic convst_n,
   input logic rfs,
   input logic busy,
   input logic pwr_down,
   input logic dout
);

   int unsigned busy_run;
   int unsigned wake_cnt;
   logic        waking;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_run <= 0;
         wake_cnt <= 0;
         waking   <= 1'b0;
      end else begin
         busy_run <= busy ? busy_run + 1 : 0;
         if (pwr_down) begin
            waking   <= 1'b1;
            wake_cnt <= 0;
         end else if (busy) begin
            waking <= 1'b0;
         end else if (waking && wake_cnt < PWRUP_CYC) begin
            wake_cnt <= wake_cnt + 1;
         end
      end
   end

   AST_CONV_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= CONV_CYC);  // R2

   AST_STAY_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && $past(convst_n)) |-> !pwr_down);  // R3

   AST_ENTER_PD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_down) |-> ($fell(busy) && !$past(convst_n)));  // R3

   AST_NO_CONV_IN_PD: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |=> !busy);  // R4

   AST_WAKE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && waking) |-> (wake_cnt >= PWRUP_CYC));  // R4

   AST_DOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rfs |=> !dout);  // R8

endmodule

bind adc_seq_ctrl adc_seq_chk #(.CONV_CYC(CONV_CYC), .PWRUP_CYC(PWRUP_CYC)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .convst_n (convst_n),
   .rfs      (rfs),
   .busy     (busy),
   .pwr_down (pwr_down),
   .dout     (dout)
);

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;

   localparam int DATA_W    = 10;
   localparam int CONV_CYC  = (250 * 2300 + 999) / 1000;  // 575
   localparam int PWRUP_CYC = (250 * 1500 + 999) / 1000;  // 375

   logic              clk = 1'b0;
   logic              rst_n;
   logic              convst_n;
   logic [DATA_W-1:0] result_in;
   logic              rfs;
   logic              sclk;
   logic              dout;
   logic              busy;
   logic              pwr_down;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   adc_seq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .convst_n(convst_n), .result_in(result_in),
      .rfs(rfs), .sclk(sclk), .dout(dout), .busy(busy), .pwr_down(pwr_down));

   // {result word, read offset after strobe, expected word of first read}
   localparam logic [41:0] VECS [6] = '{
      {10'h2A5, 22'd600, 10'h2A5},   // R9 read after completion
      {10'h15A, 22'd100, 10'h2A5},   // R9 read well before completion
      {10'h3FF, 22'd550, 10'h15A},   // R10 completion during read
      {10'h001, 22'd560, 10'h3FF},   // R10 completion during read
      {10'h200, 22'd580, 10'h200},   // R9 read just after completion
      {10'h0CC, 22'd3,   10'h200}    // R9 read right after strobe
   };

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic read_word(output logic [DATA_W-1:0] w);
      w = '0;
      rfs = 1'b1;
      cyc(2);
      for (int i = 0; i <= DATA_W; i++) begin
         sclk = 1'b1;
         cyc(2);
         if (i < DATA_W) w[DATA_W-1-i] = dout;
         sclk = 1'b0;
         cyc(2);
      end
      rfs = 1'b0;
      cyc(1);
      chk("R8 dout idle after read", int'(dout), 0);
   endtask

   initial begin
      logic [DATA_W-1:0] w;
      rst_n = 1'b0; convst_n = 1'b1; rfs = 1'b0; sclk = 1'b0; result_in = '0;
      cyc(5);
      rst_n = 1'b1;
      cyc(1);
      chk("R1 busy", int'(busy), 0);
      chk("R1 pwr_down", int'(pwr_down), 0);
      chk("R1 dout", int'(dout), 0);
      read_word(w);
      chk("R1 held result", int'(w), 0);

      // table walk: read placement relative to completion
      for (int v = 0; v < 6; v++) begin
         int dly;
         int elapsed;
         dly = int'(VECS[v][31:10]);
         result_in = VECS[v][41:32];
         convst_n = 1'b0;
         cyc(1);
         convst_n = 1'b1;
         cyc(dly - 1);
         read_word(w);
         chk($sformatf("R9 R10 vector %0d first read", v), int'(w), int'(VECS[v][9:0]));
         elapsed = dly + 4 * DATA_W + 7;
         if (elapsed < 650) cyc(650 - elapsed);
         read_word(w);
         chk($sformatf("R6 vector %0d later read", v), int'(w), int'(VECS[v][41:32]));
         read_word(w);
         chk($sformatf("R11 vector %0d re-read", v), int'(w), int'(VECS[v][41:32]));
      end

      // R2 busy length with an ignored mid-conversion strobe
      result_in = 10'h0AA;
      convst_n = 1'b0;
      cyc(1);
      convst_n = 1'b1;
      chk("R2 busy rises", int'(busy), 1);
      cyc(199);
      convst_n = 1'b0;
      cyc(1);
      convst_n = 1'b1;
      cyc(CONV_CYC - 201);
      chk("R2 busy on last cycle", int'(busy), 1);
      cyc(1);
      chk("R2 busy ends after CONV_CYC", int'(busy), 0);
      chk("R3 stays powered", int'(pwr_down), 0);
      cyc(20);

      // R3 power-down outcome
      result_in = 10'h155;
      convst_n = 1'b0;
      cyc(CONV_CYC + 1);
      chk("R3 power-down entered", int'(pwr_down), 1);
      chk("R3 busy low in power-down", int'(busy), 0);
      read_word(w);
      chk("R6 result captured before power-down", int'(w), 'h155);
      cyc(20);

      // R4/R5 wake with a strobe stored during power-up
      result_in = 10'h2F0;
      convst_n = 1'b1;
      cyc(1);
      chk("R4 pwr_down clears on wake", int'(pwr_down), 0);
      chk("R4 no conversion at wake", int'(busy), 0);
      cyc(99);
      convst_n = 1'b0;
      cyc(1);
      convst_n = 1'b1;
      cyc(PWRUP_CYC - 101);
      chk("R4 no conversion before power-up ends", int'(busy), 0);
      cyc(1);
      chk("R5 stored strobe starts conversion", int'(busy), 1);
      cyc(CONV_CYC + 5);
      chk("R3 powered after deferred conversion", int'(pwr_down), 0);

      // R7 arming, first bit, and abort by rfs low
      rfs = 1'b1;
      cyc(3);
      chk("R7 dout low before first sclk", int'(dout), 0);
      sclk = 1'b1;
      cyc(2);
      chk("R7 MSB after first sclk", int'(dout), 1);
      rfs = 1'b0;
      cyc(2);
      chk("R7 rfs low ends read", int'(dout), 0);
      sclk = 1'b0;
      cyc(2);
      read_word(w);
      chk("R5 R6 deferred conversion result", int'(w), 'h2F0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule